// File: doc/BRIEF.md
# Byte-Merging SPI Data FIFO Port

This block sits between a bus host and an SPI shift engine. The host sees one 32-bit data register, plus a few control and status registers, on a simple read/write port. Words written to the data register enter a transmit FIFO. An unpacker hands them to the shift engine one byte at a time. Bytes that the engine receives are gathered by a packer and pushed into a receive FIFO, where the host reads them back through the same data register.

A merge bit in the format register selects, for each transfer, how much one access carries. In merge mode, one access carries four serial bytes, and the lowest byte lane travels first. With merge off, one access carries a single byte in the low lane. The host sees FIFO status flags and the FIFO depths. It can flush either FIFO or the whole block with control bits that clear themselves. Two outputs give DMA requests, each sized to half a FIFO.

Register map (word offsets on `bus_addr`): 0 data, 1 format, 2 control, 3 status, 4 configuration. A read returns its value on `bus_rdata` in the cycle after the read strobe, and the value holds until the next read.

Top module: `spi_merge_fifo_port`

## Requirements
- R1: With merge inactive, a data write sends exactly one byte to the engine, equal to `bus_wdata[7:0]`. The upper lanes are ignored.
- R2: Merge is active when format bit 7 is 1 and the format word-length field [12:8] holds 7 (8-bit words). A data write then sends four bytes in this order: [7:0], [15:8], [23:16], [31:24].
- R3: If format bit 7 is 1 but field [12:8] is not 7, the write is treated as unmerged and sends only byte [7:0].
- R4: With merge inactive, each received byte reads back as `{24'h0, byte}`. With merge active, four received bytes read back as one word, with the first byte in [7:0] and the fourth in [31:24].
- R5: Status bit 23 is 1 while the transmit FIFO holds its full depth. Status bit 14 is 1 while the receive FIFO is empty. All other status bits read 0.
- R6: A data write while the transmit FIFO is full is dropped. The bytes already accepted still leave in write order.
- R7: A data read while the receive FIFO is empty returns 0 and does not change the FIFO contents.
- R8: Configuration bits [3:0] read log2(receive depth)-1 and bits [7:4] read log2(transmit depth)-1. Both defaults are depth 8, so the register reads 0x22.
- R9: Control bit 1 empties the receive FIFO and control bit 2 empties the transmit path. Each bit clears itself, and control reads 0 afterwards.
- R10: Control bit 0 empties both paths, returns format to 0x0000_0700, clears every control bit and then clears itself.
- R11: `dma_rx_req` is 1 while control bit 3 is set and the receive FIFO holds at least half its depth, and 0 otherwise.
- R12: `dma_tx_req` is 1 while control bit 4 is set and the transmit FIFO has at least half its depth free, and 0 otherwise.
- R13: After `rst`, format reads 0x0000_0700, control reads 0, status reads 0x0000_4000, and both DMA requests and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| tx_byte | output | 8 | Next byte for the shift engine |
| tx_valid | output | 1 | `tx_byte` is valid |
| tx_take | input | 1 | Engine consumes `tx_byte` |
| rx_byte | input | 8 | Byte received by the engine |
| rx_valid | input | 1 | `rx_byte` strobe |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The assertions assume the host never raises `bus_wr` and `bus_rd` together. They also assume the engine raises `tx_take` only while `tx_valid` is 1, and that the merge setting does not change while a merged receive word is half gathered. The stimulus issues one bus access at a time through tasks and pulses `tx_take` only after seeing `tx_valid`. It changes the format register only when both paths are idle and between whole four-byte groups.

// File: rtl/spi_merge_pkg.sv
package spi_merge_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DATA   = 3'd0;
  localparam logic [ADDR_W-1:0] A_FMT    = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
  localparam logic [ADDR_W-1:0] A_CONFIG = 3'd4;

  localparam int FMT_MERGE_BIT = 7;
  localparam int FMT_LEN_LO    = 8;
  localparam logic [4:0] LEN_BYTE = 5'd7;

  localparam int CTL_ALL_RST = 0;
  localparam int CTL_RX_RST  = 1;
  localparam int CTL_TX_RST  = 2;
  localparam int CTL_RX_DMA  = 3;
  localparam int CTL_TX_DMA  = 4;

  localparam int ST_RX_EMPTY = 14;
  localparam int ST_TX_FULL  = 23;
endpackage

// File: rtl/spmp_word_fifo.sv
module spmp_word_fifo #(
  parameter int WIDTH = 32,
  parameter int LOG2  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty,
  output logic [LOG2:0]    count
);
  localparam int DEPTH = 1 << LOG2;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [LOG2-1:0]  wr_ptr, rd_ptr;
  logic             push, pop;

  assign full  = (count == (LOG2+1)'(DEPTH));
  assign empty = (count == '0);
  assign push  = wr_en && !full && !flush;
  assign pop   = rd_en && !empty && !flush;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
    if (pop)  rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) int'(count) <= DEPTH); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst) (wr_en && full && !rd_en && !flush) |=> $stable(count)); // R6
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst) (rd_en && empty && !wr_en && !flush) |=> $stable(count)); // R7
endmodule

// File: rtl/spmp_tx_unpack.sv
module spmp_tx_unpack (
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        fifo_empty,
  output logic        fifo_pop,
  input  logic [32:0] fifo_data,
  output logic [7:0]  tx_byte,
  output logic        tx_valid,
  input  logic        tx_take
);
  logic        pend, have, merge_w;
  logic [31:0] word;
  logic [1:0]  idx;

  assign fifo_pop = !have && !pend && !fifo_empty;
  assign tx_valid = have;
  assign tx_byte  = word[8*idx +: 8];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pend    <= 1'b0;
      have    <= 1'b0;
      merge_w <= 1'b0;
      idx     <= '0;
      word    <= '0;
    end else begin
      pend <= fifo_pop;
      if (pend) begin
        have    <= 1'b1;
        word    <= fifo_data[31:0];
        merge_w <= fifo_data[32];
        idx     <= '0;
      end else if (have && tx_take) begin
        if (!merge_w || idx == 2'd3) have <= 1'b0;
        else                         idx  <= idx + 1'b1;
      end
    end
  end

  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (rst) (tx_valid && !merge_w) |-> (idx == 2'd0)); // R1
  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (rst) (tx_valid && !tx_take && !flush) |=> (tx_valid && $stable(tx_byte))); // R2
endmodule

// File: rtl/spmp_rx_pack.sv
module spmp_rx_pack (
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        merge,
  input  logic [7:0]  in_byte,
  input  logic        in_valid,
  output logic        push,
  output logic [31:0] push_data
);
  logic [23:0] acc;
  logic [1:0]  idx;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      acc       <= '0;
      idx       <= '0;
      push      <= 1'b0;
      push_data <= '0;
    end else begin
      push <= 1'b0;
      if (in_valid) begin
        if (!merge) begin
          push      <= 1'b1;
          push_data <= {24'h0, in_byte};
          idx       <= '0;
        end else if (idx == 2'd3) begin
          push      <= 1'b1;
          push_data <= {in_byte, acc};
          idx       <= '0;
        end else begin
          acc[8*idx +: 8] <= in_byte;
          idx             <= idx + 1'b1;
        end
      end
    end
  end

  AST_UNMERGED_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) (in_valid && !merge && !flush) |=> (push && push_data[31:8] == 24'h0)); // R4
endmodule

// File: rtl/spi_merge_fifo_port.sv
module spi_merge_fifo_port
  import spi_merge_pkg::*;
#(
  parameter int TX_LOG2 = 3,
  parameter int RX_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  input  logic              tx_take,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  output logic              dma_rx_req,
  output logic              dma_tx_req
);
  localparam int TX_DEPTH = 1 << TX_LOG2;
  localparam int RX_DEPTH = 1 << RX_LOG2;
  localparam int TX_HALF  = TX_DEPTH / 2;
  localparam int RX_HALF  = RX_DEPTH / 2;

  // register state
  logic       merge_q;
  logic [4:0] len_q;
  logic       rst_all_q, rst_rx_q, rst_tx_q, rx_dma_q, tx_dma_q;
  logic       merge_eff, tx_flush, rx_flush;
  logic       ctrl_wr, fmt_wr, data_wr, data_rd;

  // fifo side
  logic        tx_full, tx_empty, tx_pop;
  logic [32:0] tx_dout;
  logic [TX_LOG2:0] tx_count;
  logic        rx_full, rx_empty, rx_push;
  logic [31:0] rx_din, rx_dout;
  logic [RX_LOG2:0] rx_count;

  // read path
  logic        sel_data_q, rd_empty_q;
  logic [31:0] reg_q;
  logic [31:0] fmt_rd, ctrl_rd, status_rd, cfg_rd;

  assign ctrl_wr = bus_wr && bus_addr == A_CTRL;
  assign fmt_wr  = bus_wr && bus_addr == A_FMT;
  assign data_wr = bus_wr && bus_addr == A_DATA;
  assign data_rd = bus_rd && bus_addr == A_DATA;

  assign merge_eff = merge_q && (len_q == LEN_BYTE);
  assign tx_flush  = rst_tx_q || rst_all_q;
  assign rx_flush  = rst_rx_q || rst_all_q;

  always_ff @(posedge clk) begin
    if (rst || rst_all_q) begin
      merge_q   <= 1'b0;
      len_q     <= LEN_BYTE;
      rst_all_q <= 1'b0;
      rst_rx_q  <= 1'b0;
      rst_tx_q  <= 1'b0;
      rx_dma_q  <= 1'b0;
      tx_dma_q  <= 1'b0;
    end else begin
      if (fmt_wr) begin
        merge_q <= bus_wdata[FMT_MERGE_BIT];
        len_q   <= bus_wdata[FMT_LEN_LO +: 5];
      end
      if (ctrl_wr) begin
        rst_all_q <= bus_wdata[CTL_ALL_RST];
        rst_rx_q  <= bus_wdata[CTL_RX_RST];
        rst_tx_q  <= bus_wdata[CTL_TX_RST];
        rx_dma_q  <= bus_wdata[CTL_RX_DMA];
        tx_dma_q  <= bus_wdata[CTL_TX_DMA];
      end else begin
        rst_rx_q <= 1'b0;
        rst_tx_q <= 1'b0;
      end
    end
  end

  spmp_word_fifo #(.WIDTH(33), .LOG2(TX_LOG2)) u_tx_fifo (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .wr_en(data_wr), .wr_data({merge_eff, bus_wdata}),
    .rd_en(tx_pop), .rd_data(tx_dout),
    .full(tx_full), .empty(tx_empty), .count(tx_count)
  );

  spmp_tx_unpack u_unpack (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .fifo_empty(tx_empty), .fifo_pop(tx_pop), .fifo_data(tx_dout),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_take(tx_take)
  );

  spmp_rx_pack u_pack (
    .clk(clk), .rst(rst), .flush(rx_flush), .merge(merge_eff),
    .in_byte(rx_byte), .in_valid(rx_valid),
    .push(rx_push), .push_data(rx_din)
  );

  spmp_word_fifo #(.WIDTH(32), .LOG2(RX_LOG2)) u_rx_fifo (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .wr_en(rx_push), .wr_data(rx_din),
    .rd_en(data_rd), .rd_data(rx_dout),
    .full(rx_full), .empty(rx_empty), .count(rx_count)
  );

  always_comb begin
    fmt_rd    = '0;
    fmt_rd[FMT_MERGE_BIT]     = merge_q;
    fmt_rd[FMT_LEN_LO +: 5]   = len_q;
    ctrl_rd   = '0;
    ctrl_rd[CTL_ALL_RST] = rst_all_q;
    ctrl_rd[CTL_RX_RST]  = rst_rx_q;
    ctrl_rd[CTL_TX_RST]  = rst_tx_q;
    ctrl_rd[CTL_RX_DMA]  = rx_dma_q;
    ctrl_rd[CTL_TX_DMA]  = tx_dma_q;
    status_rd = '0;
    status_rd[ST_RX_EMPTY] = rx_empty;
    status_rd[ST_TX_FULL]  = tx_full;
    cfg_rd    = {24'h0, 4'(TX_LOG2 - 1), 4'(RX_LOG2 - 1)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_data_q <= 1'b0;
      rd_empty_q <= 1'b1;
      reg_q      <= '0;
    end else if (bus_rd) begin
      sel_data_q <= (bus_addr == A_DATA);
      rd_empty_q <= rx_empty;
      case (bus_addr)
        A_FMT:    reg_q <= fmt_rd;
        A_CTRL:   reg_q <= ctrl_rd;
        A_STATUS: reg_q <= status_rd;
        A_CONFIG: reg_q <= cfg_rd;
        default:  reg_q <= '0;
      endcase
    end
  end

  assign bus_rdata = sel_data_q ? (rd_empty_q ? 32'h0 : rx_dout) : reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_rx_req <= 1'b0;
      dma_tx_req <= 1'b0;
    end else begin
      dma_rx_req <= rx_dma_q && (int'(rx_count) >= RX_HALF);
      dma_tx_req <= tx_dma_q && ((TX_DEPTH - int'(tx_count)) >= TX_HALF);
    end
  end

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst) (data_rd && rx_empty) |=> (bus_rdata == 32'h0)); // R7
  AST_RX_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst) (rst_rx_q && !ctrl_wr) |=> !rst_rx_q); // R9
  AST_TX_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst) (rst_tx_q && !ctrl_wr) |=> !rst_tx_q); // R9
  AST_FMT_DEFAULT: assert property (@(posedge clk) disable iff (rst) rst_all_q |=> (len_q == LEN_BYTE && !merge_q && !rst_all_q)); // R10
  AST_DMA_RX_OFF: assert property (@(posedge clk) disable iff (rst) !rx_dma_q |=> !dma_rx_req); // R11
  AST_DMA_RX_FULL: assert property (@(posedge clk) disable iff (rst) (rx_dma_q && rx_full) |=> dma_rx_req); // R11
  AST_DMA_TX_OFF: assert property (@(posedge clk) disable iff (rst) !tx_dma_q |=> !dma_tx_req); // R12
  AST_DMA_TX_EMPTY: assert property (@(posedge clk) disable iff (rst) (tx_dma_q && tx_empty) |=> dma_tx_req); // R12
endmodule

// File: tb/spi_merge_fifo_port_tb.sv
module spi_merge_fifo_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        tx_take = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        dma_rx_req, dma_tx_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_merge_fifo_port u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_take(tx_take),
    .rx_byte(rx_byte), .rx_valid(rx_valid),
    .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
  );

  // {merge bit, length field, word}
  localparam logic [37:0] TXV [6] = '{
    {1'b0, 5'd7,  32'hA5A5_1234},
    {1'b1, 5'd7,  32'h4433_2211},
    {1'b1, 5'd7,  32'hDEAD_BEEF},
    {1'b1, 5'd15, 32'hAABB_CCDD},
    {1'b0, 5'd15, 32'h0000_00FF},
    {1'b1, 5'd7,  32'h0000_0080}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic get_byte(output logic [7:0] b, output bit ok);
    ok = 1'b0; b = '0;
    for (int i = 0; i < 20 && !ok; i++) begin
      @(negedge clk);
      if (tx_valid) ok = 1'b1;
    end
    if (ok) begin
      b = tx_byte; tx_take = 1'b1;
      @(negedge clk); tx_take = 1'b0;
    end
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    bit ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R13 reset state
    rd(3'd1, d); check("R13 fmt", d, 32'h0000_0700);
    rd(3'd2, d); check("R13 ctrl", d, 32'h0);
    rd(3'd3, d); check("R13 status", d, 32'h0000_4000);
    check("R13 dma/valid", {29'h0, dma_rx_req, dma_tx_req, tx_valid}, 32'h0);
    // R8 configuration
    rd(3'd4, d); check("R8 config", d, 32'h0000_0022);

    // R1 R2 R3 transmit vector table
    for (int v = 0; v < 6; v++) begin
      logic [37:0] e;
      int n;
      string tag;
      e = TXV[v];
      n = (e[37] && e[36:32] == 5'd7) ? 4 : 1;
      tag = (n == 4) ? "R2 merged byte" : (e[37] ? "R3 merge ignored" : "R1 single byte");
      wr(3'd1, {19'h0, e[36:32], e[37], 7'h0});
      wr(3'd0, e[31:0]);
      for (int k = 0; k < n; k++) begin
        get_byte(b, ok);
        check(tag, {23'h0, ok, b}, {23'h0, 1'b1, e[8*k +: 8]});
      end
      idle(4);
      check({tag, " no extra"}, {31'h0, tx_valid}, 32'h0);
    end

    // R4 receive, unmerged then merged
    wr(3'd1, 32'h0000_0700);
    send_rx(8'h5A); send_rx(8'hC3);
    idle(3);
    rd(3'd0, d); check("R4 unmerged first", d, 32'h0000_005A);
    rd(3'd0, d); check("R4 unmerged second", d, 32'h0000_00C3);
    wr(3'd1, 32'h0000_0780);
    send_rx(8'h01); send_rx(8'h02); send_rx(8'h03); send_rx(8'h04);
    idle(3);
    rd(3'd0, d); check("R4 merged word", d, 32'h0403_0201);
    wr(3'd1, 32'h0000_0700);

    // R7 empty read returns zero, state unchanged
    rd(3'd3, d); check("R5 rx empty flag", d, 32'h0000_4000);
    rd(3'd0, d); check("R7 empty read", d, 32'h0);
    send_rx(8'h77);
    idle(3);
    rd(3'd3, d); check("R5 rx not empty", d, 32'h0);
    rd(3'd0, d); check("R7 after empty read", d, 32'h0000_0077);

    // R5 R6 transmit full and drop
    for (int i = 0; i < 10; i++) wr(3'd0, 32'hFFFF_FF10 + 32'(i));
    idle(3);
    rd(3'd3, d); check("R5 tx full flag", d, 32'h0080_4000);
    for (int i = 0; i < 9; i++) begin
      get_byte(b, ok);
      check("R6 accepted order", {23'h0, ok, b}, {23'h0, 1'b1, 8'h10 + 8'(i)});
    end
    idle(5);
    check("R6 dropped write", {31'h0, tx_valid}, 32'h0);
    rd(3'd3, d); check("R5 tx not full", d, 32'h0000_4000);

    // R9 receive flush
    send_rx(8'h11); send_rx(8'h22);
    idle(3);
    wr(3'd2, 32'h0000_0002);
    idle(2);
    rd(3'd2, d); check("R9 rx reset self clear", d, 32'h0);
    rd(3'd3, d); check("R9 rx emptied", d, 32'h0000_4000);
    rd(3'd0, d); check("R9 rx data gone", d, 32'h0);
    // R9 transmit flush
    wr(3'd0, 32'h0000_00AA); wr(3'd0, 32'h0000_00BB);
    idle(3);
    wr(3'd2, 32'h0000_0004);
    idle(2);
    check("R9 tx valid cleared", {31'h0, tx_valid}, 32'h0);
    rd(3'd2, d); check("R9 tx reset self clear", d, 32'h0);
    wr(3'd0, 32'h0000_00CC);
    get_byte(b, ok);
    check("R9 tx first after flush", {23'h0, ok, b}, {23'h0, 1'b1, 8'hCC});

    // R10 controller reset
    wr(3'd1, 32'h0000_0F80);
    wr(3'd2, 32'h0000_0018);
    send_rx(8'h33);
    idle(3);
    wr(3'd2, 32'h0000_0019);
    idle(2);
    rd(3'd1, d); check("R10 fmt default", d, 32'h0000_0700);
    rd(3'd2, d); check("R10 ctrl cleared", d, 32'h0);
    rd(3'd3, d); check("R10 fifos empty", d, 32'h0000_4000);

    // R11 receive DMA request
    wr(3'd2, 32'h0000_0008);
    send_rx(8'h01); send_rx(8'h02); send_rx(8'h03);
    idle(3);
    check("R11 below half", {31'h0, dma_rx_req}, 32'h0);
    send_rx(8'h04);
    idle(3);
    check("R11 at half", {31'h0, dma_rx_req}, 32'h1);
    rd(3'd0, d);
    idle(2);
    check("R11 after read", {31'h0, dma_rx_req}, 32'h0);
    send_rx(8'h05);
    idle(3);
    wr(3'd2, 32'h0000_0000);
    idle(2);
    check("R11 disabled", {31'h0, dma_rx_req}, 32'h0);
    wr(3'd2, 32'h0000_0002);
    idle(2);

    // R12 transmit DMA request
    wr(3'd2, 32'h0000_0010);
    idle(2);
    check("R12 empty fifo", {31'h0, dma_tx_req}, 32'h1);
    for (int i = 0; i < 6; i++) wr(3'd0, 32'(i));
    idle(3);
    check("R12 less than half free", {31'h0, dma_tx_req}, 32'h0);
    get_byte(b, ok); get_byte(b, ok);
    idle(4);
    check("R12 half free again", {31'h0, dma_tx_req}, 32'h1);
    wr(3'd2, 32'h0000_0000);
    idle(2);
    check("R12 disabled", {31'h0, dma_tx_req}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule